// File: doc/BRIEF.md
# Dual Interval Timer with Wrap Interrupt

This block holds two independent 16-bit up-counters, called timer A and timer B. Each timer advances by one on every cycle in which its own tick enable is high. The tick enables come from outside the block. A typical system drives one enable at a 10 µs period and the other at a 100 µs period, so one count stands for one tick interval. When a timer steps from FFFF to 0000, it raises a one-cycle interrupt request on its own line.

Software reaches both timers through a single-cycle command port. A command names a timer and one of four operations: load a value, start, stop, or read. Both timers come out of reset cleared and already running. A timer that software never loads therefore interrupts after 65,536 ticks. While a debug breakpoint halt is asserted and a debug console is attached, both timers freeze. A breakpoint halt with no console attached has no effect.

Top module: `dual_itimer`

## Requirements
- R1: After reset, both counts read 0000, irq_a, irq_b and rd_valid are low, and both timers are running, so the next tick advances them.
- R2: A running, unfrozen timer adds exactly one on each cycle its tick enable is high. With the tick enable low, it keeps its value.
- R3: When a tick moves a timer from FFFF to 0000, that timer's irq line is high for exactly one cycle. This is the cycle in which the count first reads 0000. The other timer's irq line stays low.
- R4: A load command (cmd_op = 2'b00) sets the selected timer to cmd_data on the next edge. The load wins over a tick in the same cycle, and the loaded value is not incremented in that cycle.
- R5: A stop command (cmd_op = 2'b10) makes the selected timer keep its value and ignore ticks. A start command (cmd_op = 2'b01) resumes counting from the kept value.
- R6: A read command (cmd_op = 2'b11) drives rd_valid high on the following cycle for one cycle. At the same time, rd_data carries the selected count as it stood before the edge that took the command.
- R7: While halt_bkpt and console_att are both high, neither timer advances on ticks. halt_bkpt alone does not freeze the timers.
- R8: cmd_sel = 0 addresses timer A and cmd_sel = 1 addresses timer B. A command to one timer, and the tick of one timer, leave the other timer unchanged.
- R9: Starting from reset with no command, the first irq on a timer comes with its 65,536th tick and not earlier.
- R10: A load still takes effect while the timers are frozen by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_a | input | 1 | Count enable of timer A |
| tick_b | input | 1 | Count enable of timer B |
| halt_bkpt | input | 1 | Breakpoint halt in progress |
| console_att | input | 1 | Debug console attached |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 load, 01 start, 10 stop, 11 read |
| cmd_sel | input | 1 | 0 timer A, 1 timer B |
| cmd_data | input | 16 | Value for a load command |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Count returned by a read |
| irq_a | output | 1 | Wrap pulse of timer A |
| irq_b | output | 1 | Wrap pulse of timer B |

## Verification
The bench goes after the wrap edge. It starts timers at FFFF, FFFE and FFF0 and counts the irq pulses. A design that compared against the wrong value, or held irq as a level, would report zero or several pulses, or report them on the wrong line. The bench also issues a load together with a tick and a read together with a tick. A design with the wrong priority would return a value one too high, and a read registered on the wrong side of the update would return the updated count. Breakpoint halt is exercised with and without the console and combined with a load. An over-eager freeze would lose counts, and a freeze that also blocked loads would keep a stale value. The full 65,536-tick run from reset catches a design that comes up stopped or that interrupts early.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int NUM_TMR = 2;
  localparam int SEL_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_READ  = 2'b11
  } itmr_op_e;

endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/itmr_cmd_dec.sv
module itmr_cmd_dec
  import itmr_pkg::*;
#(
  parameter int NT = NUM_TMR
) (
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [SEL_W-1:0] cmd_sel_i,
  output logic [NT-1:0]    load_o,
  output logic [NT-1:0]    start_o,
  output logic [NT-1:0]    stop_o,
  output logic             rd_req_o
);

  itmr_op_e op;

  always_comb begin
    op = itmr_op_e'(cmd_op_i);
  end

  for (genvar g = 0; g < NT; g++) begin : g_dec
    logic hit;
    always_comb begin
      hit        = cmd_valid_i && (cmd_sel_i == SEL_W'(g));
      load_o[g]  = hit && (op == OP_LOAD);
      start_o[g] = hit && (op == OP_START);
      stop_o[g]  = hit && (op == OP_STOP);
    end
  end

  always_comb begin
    rd_req_o = cmd_valid_i && (op == OP_READ);
  end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             load_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             irq_o
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] count_q, count_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             adv;
  logic             count_en;

  // next state
  always_comb begin
    adv      = run_q && tick_i && !freeze_i && !load_i;
    count_en = load_i || adv;
    count_d  = load_i ? load_val_i : (count_q + ONE);
    if (start_i) begin
      run_d = 1'b1;
    end else if (stop_i) begin
      run_d = 1'b0;
    end else begin
      run_d = run_q;
    end
    irq_d = adv && (count_q == TOP_VAL);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (count_en) begin
        count_q <= count_d;
      end
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  // R2: one step per qualified tick
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !freeze_i && !load_i) |=> (count_q == $past(count_q) + ONE));

  // R3: wrap pulse coincides with a zero count and lasts one cycle
  p_irq_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0));
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R4 / R10: load lands unchanged
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(load_val_i)));

  // R5: stopped timer holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> (count_q == $past(count_q)));

  // R7: frozen timer holds
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !load_i) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/itmr_rdport.sv
module itmr_rdport
  import itmr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NT    = NUM_TMR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] cnt_i [NT],
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o
);

  logic             vld_q, vld_d;
  logic [WIDTH-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = rd_req_i;
    dat_d = cnt_i[sel_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (rd_req_i) begin
        dat_q <= dat_d;
      end
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = dat_q;

  // R6: valid only after a read request, for one cycle per request
  p_rd_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);
  p_rd_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o);

endmodule

// File: rtl/dual_itimer.sv
module dual_itimer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             halt_bkpt,
  input  logic             console_att,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic [CNT_W-1:0] cmd_data,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_a,
  output logic             irq_b
);

  logic               rst_sync_n;
  logic               freeze;
  logic [NUM_TMR-1:0] tick_v;
  logic [NUM_TMR-1:0] load_v, start_v, stop_v, irq_v;
  logic               rd_req;
  logic [CNT_W-1:0]   cnt_v [NUM_TMR];

  itmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    freeze = halt_bkpt && console_att;
    tick_v = {tick_b, tick_a};
  end

  itmr_cmd_dec #(.NT(NUM_TMR)) u_dec (
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_sel_i   (cmd_sel),
    .load_o      (load_v),
    .start_o     (start_v),
    .stop_o      (stop_v),
    .rd_req_o    (rd_req)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    itmr_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .tick_i     (tick_v[g]),
      .freeze_i   (freeze),
      .load_i     (load_v[g]),
      .start_i    (start_v[g]),
      .stop_i     (stop_v[g]),
      .load_val_i (cmd_data),
      .count_o    (cnt_v[g]),
      .irq_o      (irq_v[g])
    );
  end

  itmr_rdport #(.WIDTH(CNT_W), .NT(NUM_TMR)) u_rd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_req_i   (rd_req),
    .sel_i      (cmd_sel),
    .cnt_i      (cnt_v),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];

  // R8: a wrap happens on one timer per tick line; both lines may only pulse together when both ticked
  p_irq_own_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_a && irq_b) |-> ($past(tick_a) && $past(tick_b)));

  // R1: outputs quiet while reset is held internally
  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_a && !irq_b && !rd_valid));

endmodule

// File: tb/dual_itimer_bench.sv
`timescale 1ns/1ps
module dual_itimer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_a, tick_b, halt_bkpt, console_att;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_sel;
  logic [15:0] cmd_data;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq_a, irq_b;

  int total = 0;
  int bad   = 0;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, SP = 2'b10, RD = 2'b11;

  // vector: sel(1) start(16) ticks(8) expected(16) irq_expected(1) = 42 bits
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 16'h0010, 8'd5,  16'h0015, 1'b0},
    {1'b1, 16'hFFFE, 8'd3,  16'h0001, 1'b1},
    {1'b0, 16'hFFFF, 8'd1,  16'h0000, 1'b1},
    {1'b1, 16'h1234, 8'd0,  16'h1234, 1'b0},
    {1'b0, 16'h7FFF, 8'd2,  16'h8001, 1'b0},
    {1'b1, 16'hFFF0, 8'd20, 16'h0004, 1'b1}
  };

  always #2 clk = ~clk;

  dual_itimer u_dual_itimer (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .halt_bkpt(halt_bkpt), .console_att(console_att),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge; returns at the next negedge
  task automatic cyc(input logic cv, input logic [1:0] op, input logic sel,
                     input logic [15:0] d, input logic ta, input logic tb);
    cmd_valid = cv; cmd_op = op; cmd_sel = sel; cmd_data = d;
    tick_a = ta; tick_b = tb;
    @(negedge clk);
    cmd_valid = 1'b0; tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    cyc(1'b1, RD, sel, 16'h0, 1'b0, 1'b0);
    chk("R6 rd_valid", {15'h0, rd_valid}, 16'h1);
    v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq_a in reset", {15'h0, irq_a}, 16'h0);
    chk("R1 rd_valid in reset", {15'h0, rd_valid}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int irq_cnt, irq_b_cnt, first_at;
    tick_a = 0; tick_b = 0; halt_bkpt = 0; console_att = 0;
    cmd_valid = 0; cmd_op = 0; cmd_sel = 0; cmd_data = 0;
    @(negedge clk);
    do_reset();

    // R1 reset values
    rd(1'b0, v); chk("R1 count A after reset", v, 16'h0000);
    rd(1'b1, v); chk("R1 count B after reset", v, 16'h0000);

    // R9: free run from reset
    irq_cnt = 0; irq_b_cnt = 0; first_at = 0;
    for (int i = 1; i <= 65536; i++) begin
      cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b0);
      if (irq_a) begin
        irq_cnt++;
        if (first_at == 0) first_at = i;
      end
      if (irq_b) irq_b_cnt++;
    end
    chk("R9 irq tick index", first_at[15:0], 16'h0000);
    chk("R9 irq at 65536th tick", {15'h0, first_at == 65536}, 16'h1);
    chk("R9 irq count", irq_cnt[15:0], 16'h1);
    chk("R8 irq_b quiet", irq_b_cnt[15:0], 16'h0);
    rd(1'b0, v); chk("R3 A wrapped to zero", v, 16'h0000);
    rd(1'b1, v); chk("R8 B untouched by A ticks", v, 16'h0000);

    // table: load, tick selected timer, read
    for (int k = 0; k < NV; k++) begin
      logic        s;
      logic [15:0] st, ex;
      logic [7:0]  n;
      logic        ei;
      {s, st, n, ex, ei} = VEC[k];
      cyc(1'b1, LD, s, st, 1'b0, 1'b0);
      irq_cnt = 0; irq_b_cnt = 0;
      for (int t = 0; t < int'(n); t++) begin
        cyc(1'b0, RD, 1'b0, 16'h0, !s, s);
        if (s ? irq_b : irq_a) irq_cnt++;
        if (s ? irq_a : irq_b) irq_b_cnt++;
      end
      rd(s, v);
      chk("R2 R4 table count", v, ex);
      chk("R3 table irq pulses", irq_cnt[15:0], {15'h0, ei});
      chk("R8 table other irq", irq_b_cnt[15:0], 16'h0);
    end

    // R3: pulse lasts one cycle
    cyc(1'b1, LD, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R3 irq_a at wrap", {15'h0, irq_a}, 16'h1);
    cyc(1'b0, RD, 1'b0, 16'h0, 1'b0, 1'b0);
    chk("R3 irq_a one cycle", {15'h0, irq_a}, 16'h0);

    // R4: load beats tick
    cyc(1'b1, LD, 1'b0, 16'h0100, 1'b1, 1'b0);
    rd(1'b0, v); chk("R4 load with tick", v, 16'h0100);

    // R6: read with tick returns value before the edge
    cyc(1'b1, RD, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R6 rd_valid", {15'h0, rd_valid}, 16'h1);
    chk("R6 pre-edge value", rd_data, 16'h0100);
    cyc(1'b0, RD, 1'b0, 16'h0, 1'b0, 1'b0);
    chk("R6 rd_valid one cycle", {15'h0, rd_valid}, 16'h0);
    rd(1'b0, v); chk("R6 post-edge value", v, 16'h0101);

    // R5: stop and start
    cyc(1'b1, SP, 1'b0, 16'h0, 1'b0, 1'b0);
    repeat (5) cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b1);
    rd(1'b0, v); chk("R5 stopped holds", v, 16'h0101);
    rd(1'b1, v); chk("R8 B runs while A stopped", v, 16'h0009);
    cyc(1'b1, ST, 1'b0, 16'h0, 1'b0, 1'b0);
    repeat (2) cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b0);
    rd(1'b0, v); chk("R5 resume from held", v, 16'h0103);

    // R7: halt without console counts, with console freezes
    halt_bkpt = 1'b1;
    repeat (3) cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b1);
    rd(1'b0, v); chk("R7 halt alone counts", v, 16'h0106);
    console_att = 1'b1;
    repeat (4) cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b1);
    rd(1'b0, v); chk("R7 frozen A", v, 16'h0106);
    rd(1'b1, v); chk("R7 frozen B", v, 16'h000C);
    // R10: load while frozen
    cyc(1'b1, LD, 1'b1, 16'hABCD, 1'b0, 1'b1);
    rd(1'b1, v); chk("R10 load while frozen", v, 16'hABCD);
    halt_bkpt = 1'b0; console_att = 1'b0;
    cyc(1'b0, RD, 1'b0, 16'h0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R7 resume after halt", v, 16'hABCE);

    // R1: reset mid-run clears a stopped, loaded timer and restarts it
    cyc(1'b1, LD, 1'b0, 16'h0055, 1'b0, 1'b0);
    cyc(1'b1, SP, 1'b0, 16'h0, 1'b0, 1'b0);
    do_reset();
    cyc(1'b0, RD, 1'b0, 16'h0, 1'b1, 1'b0);
    rd(1'b0, v); chk("R1 running after reset", v, 16'h0001);
    rd(1'b1, v); chk("R1 B cleared by reset", v, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule